// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Halving Evaluator

This block evaluates the unsigned expression (1 + x + y + z·t) / 2, truncated, over several clock cycles. A small control FSM sequences a datapath that has a single shared adder and a single accumulator. The four 8-bit operands arrive one at a time on a shared data bus. The block asks for each operand in turn with a one-hot request strobe, and the bus value is captured at the clock edge that ends the request cycle.

The product z·t is built by an iterative shift-and-add loop. On each step the low bit of the t register is tested, and if it is set the left-shifted z register is added into the accumulator. The same adder then adds y, and then adds x with its carry-in forced high, which supplies the +1. The halving costs no logic: the result port is wired to the upper bits of the accumulator.

A requester raises the level `start` and waits for `done`. It then reads `result` and lowers `start` to release the block. The block accepts no new work until it has returned to idle.

Top module: `halfsum_mac_eval`

## Requirements
- R1: Out of reset, `done` and `busy` are 0 and `opnd_req` is 4'b0000.
- R2: When `start` is sampled high in idle, `busy` is 1 in the following cycle. The block then asks for the operands in the fixed order t, z, y, x. `opnd_req` is one-hot with bit0 = t, bit1 = z, bit2 = y and bit3 = x, and never has more than one bit set.
- R3: Counting the cycle after the start-sampling edge as cycle 0, t is requested in cycle 0 and z in cycle 1. After the 8-step multiply, y is requested in cycle 10 and x in cycle 11. Each operand is taken from `data_in` at the clock edge that ends its request cycle.
- R4: `done` first rises in cycle 13, and `busy` is 0 whenever `done` is 1.
- R5: When `done` is 1, `result` equals floor((1 + x + y + z·t) / 2) as a 16-bit unsigned value.
- R6: The accumulator never overflows. With all operands at 255 the result is 32768.
- R7: A zero multiplier operand or a zero multiplicand operand contributes nothing, so the result reduces to floor((1 + x + y) / 2). Both odd and even sums truncate.
- R8: While `done` is 1 and `start` stays 1, `done` stays 1 and `result` does not change. One cycle after `start` is seen low in that state, `done` and `busy` are 0.
- R9: Lowering or toggling `start` during a computation does not abort or restart it. The computation keeps the same timing and result, and `done` still rises in cycle 13.
- R10: Values on `data_in` in cycles without a request have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Level request; held until done is seen |
| data_in | input | 8 | Shared operand bus |
| opnd_req | output | 4 | One-hot operand request: bit0 t, bit1 z, bit2 y, bit3 x |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid; held while start is high |
| result | output | 16 | Accumulator bits 16..1 |

## Verification
A wrong FSM state appears on `opnd_req` within a cycle, either as a request out of order or as a request in the wrong cycle. A wrong step count in the multiply loop moves the y request away from cycle 10, so it can be seen long before `done` rises. A fault in an accumulator step or in the carry-in appears only in `result` at cycle 13. Each scenario therefore checks the request timeline and the final value separately, using operand patterns chosen so that a dropped partial product, a missing +1 or a lost top bit each change the result.

// File: rtl/halfsum_mac_pkg.sv
package halfsum_mac_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TAKE_T,
    SQ_TAKE_Z,
    SQ_MUL,
    SQ_ADD_Y,
    SQ_ADD_X,
    SQ_ADD_ONE,
    SQ_DONE
  } seq_state_e;

  localparam int unsigned REQ_N = 4;
  localparam int unsigned REQ_T = 0;
  localparam int unsigned REQ_Z = 1;
  localparam int unsigned REQ_Y = 2;
  localparam int unsigned REQ_X = 3;

endpackage

// File: rtl/halfsum_mac_adder.sv
module halfsum_mac_adder #(
  parameter int unsigned W = 17
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  function automatic logic [W:0] add_carry(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic         c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  logic [W:0] full;

  always_comb begin
    full = add_carry(a, b, cin);
    sum  = full[W-1:0];
    cout = full[W];
  end

endmodule

// File: rtl/halfsum_mac_ctrl.sv
module halfsum_mac_ctrl
  import halfsum_mac_pkg::*;
#(
  parameter int unsigned OPW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [REQ_N-1:0] opnd_req,
  output logic             mul_step,
  output logic             add_y,
  output logic             add_x_one,
  output logic             acc_clr,
  output logic             busy,
  output logic             done
);

  localparam int unsigned CNT_W = (OPW > 1) ? $clog2(OPW) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OPW - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] step_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:    if (start) state_d = SQ_TAKE_T;
      SQ_TAKE_T:  state_d = SQ_TAKE_Z;
      SQ_TAKE_Z:  state_d = SQ_MUL;
      SQ_MUL:     if (step_q == CNT_LAST) state_d = SQ_ADD_Y;
      SQ_ADD_Y:   state_d = SQ_ADD_X;
      SQ_ADD_X:   state_d = SQ_ADD_ONE;
      SQ_ADD_ONE: state_d = SQ_DONE;
      SQ_DONE:    if (!start) state_d = SQ_IDLE;
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_MUL) step_q <= step_q + 1'b1;
      else                   step_q <= '0;
    end
  end

  always_comb begin
    opnd_req        = '0;
    opnd_req[REQ_T] = (state_q == SQ_TAKE_T);
    opnd_req[REQ_Z] = (state_q == SQ_TAKE_Z);
    opnd_req[REQ_Y] = (state_q == SQ_ADD_Y);
    opnd_req[REQ_X] = (state_q == SQ_ADD_X);
    mul_step        = (state_q == SQ_MUL);
    add_y           = (state_q == SQ_ADD_X);
    add_x_one       = (state_q == SQ_ADD_ONE);
    acc_clr         = (state_q == SQ_IDLE) && start;
    done            = (state_q == SQ_DONE);
    busy            = (state_q != SQ_IDLE) && (state_q != SQ_DONE);
  end

endmodule

// File: rtl/halfsum_mac_datapath.sv
module halfsum_mac_datapath
  import halfsum_mac_pkg::*;
#(
  parameter int unsigned OPW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPW-1:0]     data_in,
  input  logic [REQ_N-1:0]   opnd_req,
  input  logic               mul_step,
  input  logic               add_y,
  input  logic               add_x_one,
  input  logic               acc_clr,
  output logic [2*OPW:0]     acc_q,
  output logic               acc_we,
  output logic               add_cout
);

  localparam int unsigned ACC_W = 2 * OPW + 1;

  logic [OPW-1:0]   t_q;    // multiplier, shifts right during MUL
  logic [ACC_W-1:0] z_q;    // multiplicand, shifts left during MUL
  logic [OPW-1:0]   y_q;
  logic [OPW-1:0]   x_q;
  logic [ACC_W-1:0] add_b;
  logic [ACC_W-1:0] add_sum;

  always_comb begin
    if (mul_step)       add_b = t_q[0] ? z_q : '0;
    else if (add_y)     add_b = ACC_W'(y_q);
    else if (add_x_one) add_b = ACC_W'(x_q);
    else                add_b = '0;
    acc_we = mul_step | add_y | add_x_one;
  end

  halfsum_mac_adder #(.W(ACC_W)) u_adder (
    .a    (acc_q),
    .b    (add_b),
    .cin  (add_x_one),
    .sum  (add_sum),
    .cout (add_cout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      z_q <= '0;
      y_q <= '0;
      x_q <= '0;
    end else begin
      if (opnd_req[REQ_T]) t_q <= data_in;
      else if (mul_step)   t_q <= t_q >> 1;
      if (opnd_req[REQ_Z]) z_q <= ACC_W'(data_in);
      else if (mul_step)   z_q <= z_q << 1;
      if (opnd_req[REQ_Y]) y_q <= data_in;
      if (opnd_req[REQ_X]) x_q <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_clr) acc_q <= '0;
    else if (acc_we)  acc_q <= add_sum;
  end

endmodule

// File: rtl/halfsum_mac_eval.sv
module halfsum_mac_eval
  import halfsum_mac_pkg::*;
#(
  parameter int unsigned OPW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [OPW-1:0]       data_in,
  output logic [REQ_N-1:0]     opnd_req,
  output logic                 busy,
  output logic                 done,
  output logic [2*OPW-1:0]     result
);

  localparam int unsigned ACC_W = 2 * OPW + 1;

  logic             mul_step;
  logic             add_y;
  logic             add_x_one;
  logic             acc_clr;
  logic             acc_we;
  logic             add_cout;
  logic [ACC_W-1:0] acc_q;

  halfsum_mac_ctrl #(.OPW(OPW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opnd_req  (opnd_req),
    .mul_step  (mul_step),
    .add_y     (add_y),
    .add_x_one (add_x_one),
    .acc_clr   (acc_clr),
    .busy      (busy),
    .done      (done)
  );

  halfsum_mac_datapath #(.OPW(OPW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_in   (data_in),
    .opnd_req  (opnd_req),
    .mul_step  (mul_step),
    .add_y     (add_y),
    .add_x_one (add_x_one),
    .acc_clr   (acc_clr),
    .acc_q     (acc_q),
    .acc_we    (acc_we),
    .add_cout  (add_cout)
  );

  // halving by wiring: drop the accumulator's bit 0
  assign result = acc_q[ACC_W-1:1];

endmodule

// File: rtl/halfsum_mac_checker.sv
module halfsum_mac_checker #(
  parameter int unsigned OPW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [3:0]       opnd_req,
  input logic             busy,
  input logic             done,
  input logic [2*OPW-1:0] result,
  input logic             mul_step,
  input logic             acc_we,
  input logic             acc_clr,
  input logic             add_cout
);

  logic [31:0] step_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        step_cnt <= '0;
    else if (mul_step) step_cnt <= step_cnt + 1;
    else               step_cnt <= '0;
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(opnd_req)); // R2

  AST_ORDER_TZ: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_req == 4'b0001) |=> (opnd_req == 4'b0010)); // R3

  AST_ORDER_YX: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_req == 4'b0100) |=> (opnd_req == 4'b1000)); // R3

  AST_MUL_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_step && step_cnt < OPW - 1) |=> mul_step); // R3

  AST_MUL_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_step && step_cnt == OPW - 1) |=> (!mul_step && opnd_req == 4'b0100)); // R3

  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> !add_cout); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (done && $stable(result))); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!done && !busy)); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> busy); // R2

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (busy || done)); // R9

endmodule

bind halfsum_mac_eval halfsum_mac_checker #(.OPW(OPW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .opnd_req (opnd_req),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .mul_step (mul_step),
  .acc_we   (acc_we),
  .acc_clr  (acc_clr),
  .add_cout (add_cout)
);

// File: tb/halfsum_mac_eval_test.sv
module halfsum_mac_eval_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  data_in = 8'h00;
  logic [3:0]  opnd_req;
  logic        busy;
  logic        done;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] junk = 8'h5A;

  halfsum_mac_eval #(.OPW(8)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .data_in  (data_in),
    .opnd_req (opnd_req),
    .busy     (busy),
    .done     (done),
    .result   (result)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_case(input logic [7:0] x, input logic [7:0] y,
                          input logic [7:0] z, input logic [7:0] t,
                          input bit drop_early);
    int exp_v;
    int kt = -1, kz = -1, ky = -1, kx = -1, kd = -1, busy0 = -1;
    logic [15:0] held = '0;
    // restated independently: sum first, then integer halving
    exp_v = (int'(z) * int'(t) + int'(x) + int'(y) + 1) / 2;
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) busy0 = busy;
      if (opnd_req == 4'b0001 && kt < 0) kt = k;
      if (opnd_req == 4'b0010 && kz < 0) kz = k;
      if (opnd_req == 4'b0100 && ky < 0) ky = k;
      if (opnd_req == 4'b1000 && kx < 0) kx = k;
      if (done) begin
        kd = k;
        held = result;
        chk(!busy, "R4 busy with done", int'(busy), 0);
        break;
      end
      if (drop_early && k == 3) start = 1'b0;
      if (drop_early && k == 5) start = 1'b1;
      if (drop_early && k == 6) start = 1'b0;
      junk = junk * 8'd13 + 8'd7;
      case (opnd_req)
        4'b0001: data_in = t;
        4'b0010: data_in = z;
        4'b0100: data_in = y;
        4'b1000: data_in = x;
        default: data_in = junk; // R10: noise outside requests
      endcase
    end
    chk(busy0 == 1, "R2 busy after start", busy0, 1);
    chk(kt == 0, "R3 t request cycle", kt, 0);
    chk(kz == 1, "R3 z request cycle", kz, 1);
    chk(ky == 10, "R3 y request cycle", ky, 10);
    chk(kx == 11, "R3 x request cycle", kx, 11);
    chk(kd == 13, drop_early ? "R9 done cycle after start toggled" : "R4 done cycle", kd, 13);
    chk(int'(held) == exp_v, "R5 R10 result value", int'(held), exp_v);
    if (!drop_early) begin
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        data_in = ~data_in;
        chk(done && result == held, "R8 done hold", int'(result), int'(held));
      end
      start = 1'b0;
    end
    @(negedge clk);
    chk(!done && !busy, "R8 release", int'({done, busy}), 0);
    data_in = 8'h00;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(done == 1'b0, "R1 done at reset", int'(done), 0);
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    chk(opnd_req == 4'b0000, "R1 request at reset", int'(opnd_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", int'({busy, done}), 0);
  endtask

  task automatic test_basic();    run_case(8'd3, 8'd5, 8'd7, 8'd9, 1'b0);     endtask
  task automatic test_even();     run_case(8'd2, 8'd3, 8'd4, 8'd5, 1'b0);     endtask
  task automatic test_max();      run_case(8'd255, 8'd255, 8'd255, 8'd255, 1'b0); endtask // R6 -> 32768
  task automatic test_zero_all(); run_case(8'd0, 8'd0, 8'd0, 8'd0, 1'b0);     endtask // R7
  task automatic test_t_zero();   run_case(8'd10, 8'd4, 8'd200, 8'd0, 1'b0);  endtask // R7
  task automatic test_z_zero();   run_case(8'd1, 8'd0, 8'd0, 8'd255, 1'b0);   endtask // R7
  task automatic test_bits();     run_case(8'd170, 8'd85, 8'd129, 8'd128, 1'b0); endtask
  task automatic test_toggle();   run_case(8'd17, 8'd33, 8'd250, 8'd199, 1'b1); endtask // R9

  initial begin
    test_reset();
    test_basic();
    test_even();
    test_max();
    test_zero_all();
    test_t_zero();
    test_z_zero();
    test_bits();
    test_toggle();
    test_basic();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule